// File: doc/BRIEF.md
# Single-Accumulator Processor Core

A small 16-bit stored-program processor that keeps one accumulator, a program counter and a hidden instruction register. Program and data live in one word-addressed memory reached through a single port, so instruction fetches and operand accesses take turns on the same address, data and write-enable lines. Every instruction is one word: a 4-bit operation code in bits 15..12 and a 12-bit word address in bits 11..0.

The memory is a single-port RAM outside the core. A write is committed at the rising clock edge while `mem_we` is high. Read data reflects `mem_addr` within the same cycle. A cycle with `mem_req` high is one memory access. The number of clock cycles an instruction takes equals the number of memory accesses it makes. The core runs from address 0 after reset until it meets a stop instruction. It then raises `halted` and stays there until reset.

Top module: `acc_core`

## Requirements
- R1: An instruction word carries its operation in bits [15:12] and an operand word address in bits [11:0]. Codes: 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump when A >= 0, 6 jump when A != 0, 7 stop.
- R2: While reset is low, `halted` and `mem_we` are low. The first cycle after reset fetches from address 0.
- R3: Load (0) and store (1) take two cycles: a fetch at PC, then one access at the operand address. Load copies the word into A. Store writes A to that word, and `mem_we` is high only in that second cycle.
- R4: Add (2) takes two cycles and sets A to (A + mem[S]) mod 2^16.
- R5: Subtract (3) takes two cycles and sets A to (A - mem[S]) mod 2^16.
- R6: Jump (4) takes one cycle, and the next fetch is from the operand address.
- R7: Code 5 takes one cycle. It branches to the operand address when A[15] is 0; otherwise execution falls through to PC+1.
- R8: Code 6 takes one cycle. It branches when A is not 0x0000; otherwise execution falls through.
- R9: Stop (7) takes one cycle. Afterwards `halted` stays high, `mem_req` and `mem_we` stay low, and `mem_addr` holds the stop address plus one until reset.
- R10: Codes 8 to 15 act as one-cycle no-operations. They leave A and memory unchanged, and execution continues at the next word.
- R11: Each fetch advances the PC by exactly one, so the fetch addresses of a straight program run 0, 1, 2, ... with operand accesses in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address of the current access |
| mem_wdata | output | 16 | Data to write (the accumulator) |
| mem_we | output | 1 | Write strobe, committed at the clock edge |
| mem_req | output | 1 | High in every cycle that accesses memory |
| mem_rdata | input | 16 | Read data of the word at `mem_addr` |
| halted | output | 1 | Core has executed stop |

## Verification
On every cycle, the assertions check the port-level invariants of stopping and storing. Once `halted` rises, it stays high, the memory port stays idle and the address holds. A write strobe lasts a single cycle and always comes with an access request. The arithmetic results, the branch decisions for each accumulator sign and zero case, the handling of reserved codes, the fetch address sequence and the cycle count of each instruction can only be shown by the bench's programs. The bench runs them against its own memory model and checks the stored results and the measured cycle totals.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_req,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_LDA = OPW'(0);
  localparam logic [OPW-1:0] OP_STA = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD = OPW'(2);
  localparam logic [OPW-1:0] OP_SUB = OPW'(3);
  localparam logic [OPW-1:0] OP_JMP = OPW'(4);
  localparam logic [OPW-1:0] OP_JGE = OPW'(5);
  localparam logic [OPW-1:0] OP_JNE = OPW'(6);
  localparam logic [OPW-1:0] OP_STP = OPW'(7);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_t;

  state_t        state;
  logic [AW-1:0] pc;
  logic [DW-1:0] acc;
  logic [DW-1:0] ir;

  wire [OPW-1:0] op_f  = mem_rdata[DW-1:AW];
  wire [AW-1:0]  arg_f = mem_rdata[AW-1:0];
  wire [OPW-1:0] op_x  = ir[DW-1:AW];

  logic take_jump;
  logic needs_data;

  always_comb begin
    case (op_f)
      OP_JMP:  take_jump = 1'b1;
      OP_JGE:  take_jump = ~acc[DW-1];
      OP_JNE:  take_jump = |acc;
      default: take_jump = 1'b0;
    endcase
  end

  assign needs_data = (op_f == OP_LDA) || (op_f == OP_STA) ||
                      (op_f == OP_ADD) || (op_f == OP_SUB);

  assign mem_addr  = (state == S_EXEC) ? ir[AW-1:0] : pc;
  assign mem_wdata = acc;
  assign mem_we    = (state == S_EXEC) && (op_x == OP_STA);
  assign mem_req   = (state != S_HALT);
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      acc   <= '0;
      ir    <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir <= mem_rdata;
          pc <= take_jump ? arg_f : pc + AW'(1);
          if (needs_data)         state <= S_EXEC;
          else if (op_f == OP_STP) state <= S_HALT;
        end
        S_EXEC: begin
          case (op_x)
            OP_LDA:  acc <= mem_rdata;
            OP_ADD:  acc <= acc + mem_rdata;
            OP_SUB:  acc <= acc - mem_rdata;
            default: acc <= acc;
          endcase
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_req,
  input logic          halted
);
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !mem_we));

  assert_halt_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr));

  assert_store_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_store_is_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

bind acc_core acc_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_req(mem_req), .halted(halted)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        mem_req;
  logic [15:0] mem_rdata;
  logic        halted;

  logic [15:0] mem [0:4095];
  int checks = 0;
  int fails = 0;
  int cyc;
  logic [11:0] trace [0:15];

  always #2 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_req(mem_req), .mem_rdata(mem_rdata), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic run();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 300) begin
      if (cyc < 16) trace[cyc] = mem_addr;
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 300) chk(1'b0, "watchdog", cyc, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [15:0] va [0:7];
  logic [15:0] vb [0:7];
  logic [15:0] vt [0:5];

  initial begin
    va[0]=16'h0AA0; vb[0]=16'h0110;
    va[1]=16'hFFFF; vb[1]=16'h0001;
    va[2]=16'h0000; vb[2]=16'h0001;
    va[3]=16'h8000; vb[3]=16'h0001;
    va[4]=16'h7FFF; vb[4]=16'h7FFF;
    va[5]=16'h1234; vb[5]=16'hFEDC;
    va[6]=16'hFFFF; vb[6]=16'hFFFF;
    va[7]=16'h0001; vb[7]=16'h8000;
    vt[0]=16'h0000; vt[1]=16'h0001; vt[2]=16'h7FFF;
    vt[3]=16'h8000; vt[4]=16'hFFFF; vt[5]=16'h0100;

    // R2: reset state
    repeat (2) @(negedge clk);
    chk(!halted && !mem_we, "R2 reset outputs", {halted, mem_we}, 0);

    // R1 R3 R4 R11: straight program, trace and cycles
    clear_mem();
    mem[0]=ins(0,12'h040); mem[1]=ins(2,12'h041);
    mem[2]=ins(1,12'h042); mem[3]=ins(7,0);
    mem[12'h040]=16'h0AA0; mem[12'h041]=16'h0110;
    run();
    chk(trace[0]==12'h000, "R2 first fetch at 0", trace[0], 0);
    chk(mem[12'h042]==16'h0BB0, "R4 add result", mem[12'h042], 16'h0BB0);
    chk(cyc==7, "R3 cycle count", cyc, 7);
    begin
      logic [11:0] e [0:6];
      e[0]=12'h000; e[1]=12'h040; e[2]=12'h001; e[3]=12'h041;
      e[4]=12'h002; e[5]=12'h042; e[6]=12'h003;
      for (int i = 0; i < 7; i++)
        chk(trace[i]==e[i], "R11 address trace", trace[i], e[i]);
    end
    // R9: idle after stop
    for (int i = 0; i < 10; i++) begin
      chk(halted && !mem_req && !mem_we && mem_addr==12'h004,
          "R9 halted idle", {halted, mem_req, mem_we, mem_addr}, {3'b100, 12'h004});
      @(negedge clk);
    end

    // R4 R5: add/subtract sweep
    for (int k = 0; k < 8; k++) begin
      clear_mem();
      mem[0]=ins(0,12'h040); mem[1]=ins(2,12'h041); mem[2]=ins(1,12'h042);
      mem[3]=ins(0,12'h040); mem[4]=ins(3,12'h041); mem[5]=ins(1,12'h043);
      mem[6]=ins(7,0);
      mem[12'h040]=va[k]; mem[12'h041]=vb[k];
      run();
      chk(mem[12'h042]==16'(va[k]+vb[k]), "R4 add wrap", mem[12'h042], 16'(va[k]+vb[k]));
      chk(mem[12'h043]==16'(va[k]-vb[k]), "R5 sub wrap", mem[12'h043], 16'(va[k]-vb[k]));
      chk(cyc==13, "R5 cycle count", cyc, 13);
    end

    // R6 R7 R8: jumps over accumulator values
    for (int op = 4; op <= 6; op++) begin
      for (int k = 0; k < 6; k++) begin
        logic taken;
        logic [15:0] exp;
        clear_mem();
        mem[0]=ins(0,12'h040); mem[1]=ins(op,12'h005);
        mem[2]=ins(0,12'h041); mem[3]=ins(1,12'h043); mem[4]=ins(7,0);
        mem[5]=ins(0,12'h042); mem[6]=ins(1,12'h043); mem[7]=ins(7,0);
        mem[12'h040]=vt[k]; mem[12'h041]=16'h1111; mem[12'h042]=16'h7777;
        taken = (op==4) ? 1'b1 : (op==5) ? !vt[k][15] : (vt[k]!=16'h0);
        exp = taken ? 16'h7777 : 16'h1111;
        run();
        if (op==4)      chk(mem[12'h043]==exp, "R6 jump", mem[12'h043], exp);
        else if (op==5) chk(mem[12'h043]==exp, "R7 jump if ge", mem[12'h043], exp);
        else            chk(mem[12'h043]==exp, "R8 jump if ne", mem[12'h043], exp);
        chk(cyc==8, "R6 R7 R8 one-cycle jump", cyc, 8);
        chk(trace[3]==(taken ? 12'h005 : 12'h002), "R7 R8 next fetch", trace[3],
            taken ? 5 : 2);
      end
    end

    // R10: reserved codes
    for (int op = 8; op < 16; op++) begin
      clear_mem();
      mem[0]=ins(0,12'h040); mem[1]=ins(op,12'h041);
      mem[2]=ins(1,12'h042); mem[3]=ins(7,0);
      mem[12'h040]=16'hA5C3; mem[12'h041]=16'h5555;
      run();
      chk(mem[12'h042]==16'hA5C3, "R10 A unchanged", mem[12'h042], 16'hA5C3);
      chk(mem[12'h041]==16'h5555, "R10 memory unchanged", mem[12'h041], 16'h5555);
      chk(cyc==6, "R10 one cycle", cyc, 6);
    end

    // R1 R9: stop at a later address holds PC
    clear_mem();
    mem[0]=ins(4,12'h123); mem[12'h123]=ins(7,0);
    run();
    chk(cyc==2, "R1 R9 stop cycles", cyc, 2);
    repeat (3) @(negedge clk);
    chk(mem_addr==12'h124 && halted, "R9 pc hold", mem_addr, 12'h124);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule